// File: doc/BRIEF.md
# Chained DMA Channel Controller

This block is a single-channel bus-master DMA engine. Software programs it through three 32-bit words on a simple register port: a control/status word, a transfer address and a byte count. A buffer is described by writing its length and then its start address. The address write places the pair in a one-deep "next" slot. When no buffer is active and DMA is enabled, the slot moves into the active registers. A second buffer can be queued while the first one runs, so that one buffer chains straight into the next.

The active buffer moves through a simplified memory port as bursts. Each burst is one request with a byte length and is held until the memory acknowledges it. The burst size and the transfer direction come from the control word. Requests go out only while the attached device signals that it is ready. Each acknowledged burst advances the address and reduces the remaining count. When the count reaches zero the block records terminal count and may raise an interrupt. It then either chains into the queued buffer or stops. A memory error, an interrupt from the device and terminal count are each kept in their own status bits. A soft reset lets the outstanding bus cycle finish before it clears the channel.

Top module: `chain_dma_ctrl`

## Requirements
- R1: After reset, every register reads zero, `mem_req` is low and `irq` is low.
- R2: The register at offset 0x0 is control/status, 0x4 returns the current transfer address and 0x8 returns the remaining byte count. Any other offset reads zero. The control/status bits are: 0 interrupt pending, 1 error pending, 2 draining, 4 interrupt enable, 7 soft reset (reads 0), 8 write direction, 9 DMA enable, 10 cycle pending (a request is outstanding), 13 count enable (stored only), 14 terminal count, 19:18 burst size, 23 terminal-count interrupt disable, 24 chain enable, 25 active (DMA enable and a loaded buffer), 26 current buffer loaded, 27 next buffer loaded.
- R3: The burst size code in bits 19:18 selects the burst: 00 gives 16 bytes, 01 gives 32 bytes, 10 gives 4 bytes and 11 gives 64 bytes. Each request carries the smaller of the burst size and the remaining count. An acknowledged burst without error adds its length to the address and subtracts it from the count.
- R4: A count write is staged. An address write stores the address together with the staged count in the next slot and sets bit 27. While bit 27 is set, address writes are ignored. The count keeps only its low 24 bits.
- R5: With DMA enabled and no current buffer, a queued pair moves into the active registers. This clears bit 27 and sets bit 26.
- R6: When the active count is zero and no request is outstanding, terminal count (bit 14) is set. If chain enable is set and a pair is queued, that pair becomes active in the same cycle. Otherwise bit 26 clears and DMA enable (bit 9) clears, and any queued pair stays in the slot.
- R7: Terminal count sets interrupt pending unless bit 23 is set, in which case only terminal count is recorded. A high `dev_irq` sets interrupt pending and leaves terminal count unchanged.
- R8: A `mem_err` together with `mem_ack` sets error pending, clears DMA enable and leaves the address and count unchanged.
- R9: Bits 0, 1 and 14 clear when written with 1. An event in the same cycle wins over the clear.
- R10: `irq` is high exactly when interrupt enable is set and interrupt pending or error pending is set.
- R11: Writing 1 to bit 7 starts a soft reset. While it drains, bit 2 reads 1, register writes are ignored and no new request is issued. The outstanding request stays held and bit 10 stays set until it is acknowledged. In the cycle after nothing is outstanding, every register returns to its reset value.
- R12: A request is issued only when DMA is enabled, a buffer is loaded, its count is nonzero, `dev_rdy` is high, no request is outstanding and no reset is draining. Address and length stay stable until `mem_ack`.
- R13: `mem_write` follows the write direction bit 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Burst request, held until acknowledge |
| mem_addr | output | ADDR_W | Burst start address |
| mem_len | output | 7 | Burst length in bytes |
| mem_write | output | 1 | Burst direction, 1 = write to memory |
| mem_ack | input | 1 | Burst completed |
| mem_err | input | 1 | Burst failed, valid with mem_ack |
| dev_rdy | input | 1 | Device ready for data |
| dev_irq | input | 1 | Device interrupt event |
| irq | output | 1 | Interrupt output |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and a 24-bit count. With these values, a count write of all ones shows the truncation to 24 bits directly on a read of the count register. Its memory model acknowledges after a short fixed latency and can hold its acknowledge indefinitely. This makes a soft reset with a request still in flight reachable, and lets the bench watch the drain bits stay up before they fall. Short buffer lengths combined with all four burst codes produce partial final bursts, single-burst buffers and a two-buffer chain within a few dozen cycles each.

// File: rtl/dma_chain_pkg.sv
`timescale 1ns/1ps
package dma_chain_pkg;
  localparam int LEN_W = 7;

  localparam logic [3:0] OFS_CSR  = 4'h0;
  localparam logic [3:0] OFS_ADDR = 4'h4;
  localparam logic [3:0] OFS_CNT  = 4'h8;

  localparam int B_IP    = 0;
  localparam int B_EP    = 1;
  localparam int B_DRAIN = 2;
  localparam int B_IEN   = 4;
  localparam int B_RST   = 7;
  localparam int B_WR    = 8;
  localparam int B_EN    = 9;
  localparam int B_CYC   = 10;
  localparam int B_CEN   = 13;
  localparam int B_TC    = 14;
  localparam int B_BSZ   = 18;
  localparam int B_TCID  = 23;
  localparam int B_CHAIN = 24;
  localparam int B_ACT   = 25;
  localparam int B_CUR   = 26;
  localparam int B_NXT   = 27;

  typedef enum logic [1:0] {
    BSZ_4W  = 2'b00,
    BSZ_8W  = 2'b01,
    BSZ_1W  = 2'b10,
    BSZ_16W = 2'b11
  } bsz_e;

  function automatic logic [LEN_W-1:0] burst_bytes(input bsz_e b);
    case (b)
      BSZ_4W:  return 7'd16;
      BSZ_8W:  return 7'd32;
      BSZ_1W:  return 7'd4;
      default: return 7'd64;
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] beat_len(input logic [31:0] remain, input bsz_e b);
    logic [LEN_W-1:0] lim;
    lim = burst_bytes(b);
    return (remain < 32'(lim)) ? remain[LEN_W-1:0] : lim;
  endfunction
endpackage

// File: rtl/dma_next_slot.sv
`timescale 1ns/1ps
module dma_next_slot #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cnt_wr,
  input  logic              addr_wr,
  input  logic [31:0]       wdata,
  input  logic              take,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic [CNT_W-1:0]  nxt_cnt,
  output logic              nxt_valid
);
  logic [CNT_W-1:0] stage_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_cnt <= '0;
      nxt_addr  <= '0;
      nxt_cnt   <= '0;
      nxt_valid <= 1'b0;
    end else if (clr) begin
      stage_cnt <= '0;
      nxt_addr  <= '0;
      nxt_cnt   <= '0;
      nxt_valid <= 1'b0;
    end else begin
      if (cnt_wr) stage_cnt <= wdata[CNT_W-1:0];
      if (take) nxt_valid <= 1'b0;
      if (addr_wr && !nxt_valid) begin
        nxt_addr  <= wdata[ADDR_W-1:0];
        nxt_cnt   <= stage_cnt;
        nxt_valid <= 1'b1;
      end
    end
  end

  // R4: an occupied slot is never overwritten
  p_slot_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_valid && !take && !clr |=> nxt_valid && $stable(nxt_addr) && $stable(nxt_cnt));
endmodule

// File: rtl/dma_mover.sv
`timescale 1ns/1ps
module dma_mover
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              blk,
  input  logic              dma_en,
  input  logic              chain_en,
  input  bsz_e              bsz,
  input  logic              dev_rdy,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [ADDR_W-1:0] nxt_addr,
  input  logic [CNT_W-1:0]  nxt_cnt,
  input  logic              nxt_valid,
  output logic              req,
  output logic [LEN_W-1:0]  len,
  output logic [ADDR_W-1:0] act_addr,
  output logic [CNT_W-1:0]  act_cnt,
  output logic              act_valid,
  output logic              take,
  output logic              buf_done,
  output logic              stop_evt,
  output logic              err_evt
);
  logic acc, issue;

  assign acc      = req && mem_ack;
  assign err_evt  = acc && mem_err;
  assign buf_done = act_valid && (act_cnt == '0) && !req;
  assign take     = nxt_valid && !clr && ((!act_valid && dma_en) || (buf_done && chain_en));
  assign stop_evt = buf_done && !(chain_en && nxt_valid);
  assign issue    = dma_en && act_valid && (act_cnt != '0) && !req && dev_rdy && !blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req <= 1'b0; len <= '0; act_addr <= '0; act_cnt <= '0; act_valid <= 1'b0;
    end else if (clr) begin
      req <= 1'b0; len <= '0; act_addr <= '0; act_cnt <= '0; act_valid <= 1'b0;
    end else begin
      if (issue) begin
        req <= 1'b1;
        len <= beat_len(32'(act_cnt), bsz);
      end
      if (acc) begin
        req <= 1'b0;
        if (!mem_err) begin
          act_addr <= act_addr + ADDR_W'(len);
          act_cnt  <= act_cnt - CNT_W'(len);
        end
      end
      if (take) begin
        act_addr  <= nxt_addr;
        act_cnt   <= nxt_cnt;
        act_valid <= 1'b1;
      end else if (buf_done) begin
        act_valid <= 1'b0;
      end
    end
  end

  // R12: a request holds its address and length until acknowledged
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req && !mem_ack && !clr |=> req && $stable(act_addr) && $stable(len));
  // R3: a request never asks for more than remains, nor for nothing
  p_len_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (len != '0) && (CNT_W'(len) <= act_cnt));
  // R3: an accepted burst reduces the count by its length
  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !mem_err && !clr |=> act_cnt == $past(act_cnt) - CNT_W'($past(len)));
  // R8: a failed burst leaves the buffer position unchanged
  p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt && !clr |=> $stable(act_addr) && $stable(act_cnt));
endmodule

// File: rtl/chain_dma_ctrl.sv
`timescale 1ns/1ps
module chain_dma_ctrl
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LEN_W-1:0]  mem_len,
  output logic              mem_write,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic              dev_rdy,
  input  logic              dev_irq,
  output logic              irq
);
  logic ip, ep, ien, wr_dir, dma_en, cen, tc, tcid, chain_en, rst_busy;
  bsz_e bsz;
  logic clr, csr_wr, cnt_wr, addr_wr;
  logic [ADDR_W-1:0] nxt_addr, act_addr;
  logic [CNT_W-1:0]  nxt_cnt, act_cnt;
  logic nxt_valid, act_valid, take, buf_done, stop_evt, err_evt;
  logic [31:0] csr_rd;

  assign clr     = rst_busy && (!mem_req || mem_ack);
  assign csr_wr  = reg_wr && (reg_addr == OFS_CSR) && !rst_busy;
  assign cnt_wr  = reg_wr && (reg_addr == OFS_CNT) && !rst_busy;
  assign addr_wr = reg_wr && (reg_addr == OFS_ADDR) && !rst_busy;

  dma_next_slot #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) slot_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cnt_wr(cnt_wr), .addr_wr(addr_wr),
    .wdata(reg_wdata), .take(take), .nxt_addr(nxt_addr), .nxt_cnt(nxt_cnt),
    .nxt_valid(nxt_valid)
  );

  dma_mover #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) mover_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .blk(rst_busy), .dma_en(dma_en),
    .chain_en(chain_en), .bsz(bsz), .dev_rdy(dev_rdy), .mem_ack(mem_ack),
    .mem_err(mem_err), .nxt_addr(nxt_addr), .nxt_cnt(nxt_cnt), .nxt_valid(nxt_valid),
    .req(mem_req), .len(mem_len), .act_addr(act_addr), .act_cnt(act_cnt),
    .act_valid(act_valid), .take(take), .buf_done(buf_done), .stop_evt(stop_evt),
    .err_evt(err_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || clr) begin
      ip <= 1'b0; ep <= 1'b0; ien <= 1'b0; wr_dir <= 1'b0; dma_en <= 1'b0;
      cen <= 1'b0; tc <= 1'b0; tcid <= 1'b0; chain_en <= 1'b0; rst_busy <= 1'b0;
      bsz <= BSZ_4W;
    end else begin
      if (csr_wr) begin
        if (reg_wdata[B_RST]) begin
          rst_busy <= 1'b1;
        end else begin
          ien      <= reg_wdata[B_IEN];
          wr_dir   <= reg_wdata[B_WR];
          dma_en   <= reg_wdata[B_EN];
          cen      <= reg_wdata[B_CEN];
          bsz      <= bsz_e'(reg_wdata[B_BSZ+1:B_BSZ]);
          tcid     <= reg_wdata[B_TCID];
          chain_en <= reg_wdata[B_CHAIN];
          if (reg_wdata[B_IP]) ip <= 1'b0;
          if (reg_wdata[B_EP]) ep <= 1'b0;
          if (reg_wdata[B_TC]) tc <= 1'b0;
        end
      end
      if (buf_done) begin
        tc <= 1'b1;
        if (!tcid) ip <= 1'b1;
      end
      if (dev_irq) ip <= 1'b1;
      if (err_evt) begin
        ep     <= 1'b1;
        dma_en <= 1'b0;
      end
      if (stop_evt) dma_en <= 1'b0;
    end
  end

  assign mem_addr  = act_addr;
  assign mem_write = wr_dir;
  assign irq       = ien && (ip || ep);

  always_comb begin
    csr_rd                   = '0;
    csr_rd[B_IP]             = ip;
    csr_rd[B_EP]             = ep;
    csr_rd[B_DRAIN]          = rst_busy;
    csr_rd[B_IEN]            = ien;
    csr_rd[B_WR]             = wr_dir;
    csr_rd[B_EN]             = dma_en;
    csr_rd[B_CYC]            = mem_req;
    csr_rd[B_CEN]            = cen;
    csr_rd[B_TC]             = tc;
    csr_rd[B_BSZ+1:B_BSZ]    = bsz;
    csr_rd[B_TCID]           = tcid;
    csr_rd[B_CHAIN]          = chain_en;
    csr_rd[B_ACT]            = dma_en && act_valid;
    csr_rd[B_CUR]            = act_valid;
    csr_rd[B_NXT]            = nxt_valid;
    case (reg_addr)
      OFS_CSR:  reg_rdata = csr_rd;
      OFS_ADDR: reg_rdata = 32'(act_addr);
      OFS_CNT:  reg_rdata = 32'(act_cnt);
      default:  reg_rdata = '0;
    endcase
  end

  // R6: a finished buffer always records terminal count
  p_tc_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_done && !clr |=> tc);
  // R8: a failed burst halts the channel and flags the error
  p_err_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt && !clr |=> ep && !dma_en);
  // R11: the drain waits for the outstanding request
  p_drain_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_busy && mem_req && !mem_ack |=> rst_busy && mem_req);
  // R11: the drain ends with every register cleared
  p_drain_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !rst_busy && !mem_req && !dma_en && !act_valid && !nxt_valid);
  // R12: nothing new is issued while draining
  p_no_issue_drain_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rst_busy && !mem_req |=> !mem_req);
endmodule

// File: tb/chain_dma_ctrl_tb_top.sv
`timescale 1ns/1ps
module chain_dma_ctrl_tb_top;
  localparam logic [3:0] A_CSR = 4'h0, A_ADR = 4'h4, A_CNT = 4'h8;
  localparam logic [31:0] M_IP = 32'h1, M_EP = 32'h2, M_DRN = 32'h4, M_IEN = 32'h10,
    M_RST = 32'h80, M_WR = 32'h100, M_EN = 32'h200, M_CYC = 32'h400, M_TC = 32'h4000,
    M_TCID = 32'h80_0000, M_CHN = 32'h100_0000, M_ACT = 32'h200_0000,
    M_CUR = 32'h400_0000, M_NXT = 32'h800_0000;

  localparam int NV = 6;
  localparam int V_CODE [NV] = '{0, 1, 2, 3, 3, 0};
  localparam int V_LEN  [NV] = '{40, 100, 12, 64, 130, 3};
  localparam int V_BASE [NV] = '{32'h100, 32'h200, 32'h300, 32'h1000, 32'h2000, 32'h3000};

  logic clk = 0, rst_n = 0;
  logic [3:0] reg_addr = '0;
  logic reg_wr = 0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_write, irq;
  logic [31:0] mem_addr;
  logic [6:0] mem_len;
  logic mem_ack = 0, mem_err = 0, dev_rdy = 1, dev_irq = 0;

  int checks = 0, errors = 0, bursts = 0, wait_c = 0;
  int last_len = 0;
  logic last_wr = 0, ack_hold = 0, err_inj = 0, done = 0;
  logic [31:0] v;

  always #2 clk = ~clk;

  chain_dma_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len),
    .mem_write(mem_write), .mem_ack(mem_ack), .mem_err(mem_err), .dev_rdy(dev_rdy),
    .dev_irq(dev_irq), .irq(irq)
  );

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 0;
      mem_err = 0;
    end else if (mem_req && !ack_hold) begin
      if (wait_c >= 1) begin
        mem_ack = 1; mem_err = err_inj; wait_c = 0;
        bursts++; last_len = int'(mem_len); last_wr = mem_write;
      end else wait_c++;
    end
  end

  function automatic int bb(input int code);
    return code == 0 ? 16 : code == 1 ? 32 : code == 2 ? 4 : 64;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_clear(input logic [31:0] mask);
    logic [31:0] s;
    int n = 0;
    repeat (2) @(negedge clk);
    rd(A_CSR, s);
    while ((s & mask) != 0 && n < 2000) begin
      @(negedge clk); rd(A_CSR, s); n++;
    end
    if (n >= 2000) chk("timeout", s & mask, 0);
  endtask

  task automatic soft_reset();
    wr(A_CSR, M_RST);
    wait_clear(M_DRN);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(A_CSR, v); chk("R1 csr", v, 0);
    rd(A_ADR, v); chk("R1 addr", v, 0);
    rd(A_CNT, v); chk("R1 count", v, 0);
    chk("R1 irq/req", {irq, mem_req}, 0);

    // Vector table: R2 R3 R5 R6 R7 R10 R13
    for (int i = 0; i < NV; i++) begin
      int nb, lastb;
      logic [31:0] cfg;
      nb = (V_LEN[i] + bb(V_CODE[i]) - 1) / bb(V_CODE[i]);
      lastb = V_LEN[i] - (nb - 1) * bb(V_CODE[i]);
      cfg = (32'(V_CODE[i]) << 18) | ((i % 2) ? M_WR : 0) | M_IEN;
      wr(A_CSR, cfg | M_TC | M_IP | M_EP);
      wr(A_CNT, 32'(V_LEN[i]));
      wr(A_ADR, 32'(V_BASE[i]));
      bursts = 0;
      wr(A_CSR, cfg | M_EN);
      wait_clear(M_CUR | M_CYC);
      chk("R3 burst count", 32'(bursts), 32'(nb));
      chk("R3 last burst length", 32'(last_len), 32'(lastb));
      chk("R13 direction", {31'b0, last_wr}, 32'(i % 2));
      rd(A_ADR, v); chk("R5 end address", v, 32'(V_BASE[i] + V_LEN[i]));
      rd(A_CNT, v); chk("R5 residue", v, 0);
      rd(A_CSR, v); chk("R6 R7 tc/ip/en", v & (M_TC | M_IP | M_EN), M_TC | M_IP);
      chk("R10 irq", {31'b0, irq}, 1);
    end

    // R4 queue occupancy and staging
    soft_reset();
    wr(A_CNT, 32'h10); wr(A_ADR, 32'h5000);
    rd(A_CSR, v); chk("R4 next loaded", v & (M_NXT | M_CUR), M_NXT);
    wr(A_CNT, 32'h20); wr(A_ADR, 32'h6000);
    bursts = 0;
    wr(A_CSR, (32'd3 << 18) | M_EN);
    wait_clear(M_CUR | M_CYC);
    rd(A_ADR, v); chk("R4 second address ignored", v, 32'h5010);
    chk("R4 single burst", 32'(bursts), 1);

    // R4 truncation, R12 dev_rdy gating
    soft_reset();
    dev_rdy = 0;
    wr(A_CNT, 32'hFFFF_FFFF); wr(A_ADR, 32'h7000);
    wr(A_CSR, M_EN);
    repeat (3) @(negedge clk);
    rd(A_CNT, v); chk("R4 count truncated", v, 32'h00FF_FFFF);
    chk("R12 no request without dev_rdy", {31'b0, mem_req}, 0);
    rd(A_CSR, v); chk("R2 active bit", v & M_ACT, M_ACT);
    soft_reset();
    rd(A_CSR, v); chk("R11 idle reset clears", v, 0);
    dev_rdy = 1;

    // R6 chaining
    bursts = 0;
    wr(A_CSR, M_CHN | M_EN);
    wr(A_CNT, 48); wr(A_ADR, 32'h8000);
    wr(A_CNT, 20); wr(A_ADR, 32'h9000);
    wait_clear(M_CUR | M_NXT | M_CYC);
    chk("R6 chained bursts", 32'(bursts), 5);
    rd(A_ADR, v); chk("R6 chained end address", v, 32'h9014);
    rd(A_CSR, v); chk("R6 R10 tc ip, enable dropped", v & (M_TC | M_IP | M_EN), M_TC | M_IP);
    chk("R10 irq masked", {31'b0, irq}, 0);

    // R6 stop without chain enable
    bursts = 0;
    wr(A_CSR, M_EN | M_TC | M_IP);
    wr(A_CNT, 16); wr(A_ADR, 32'hA000);
    wr(A_CNT, 16); wr(A_ADR, 32'hB000);
    wait_clear(M_CUR | M_CYC);
    rd(A_CSR, v); chk("R6 stop keeps queued pair", v & (M_EN | M_NXT), M_NXT);
    rd(A_ADR, v); chk("R6 first buffer end", v, 32'hA010);
    wr(A_CSR, M_EN);
    wait_clear(M_CUR | M_NXT | M_CYC);
    rd(A_ADR, v); chk("R5 queued pair runs on enable", v, 32'hB010);

    // R7 terminal-count interrupt disable
    wr(A_CSR, M_TCID | M_IEN | M_EN | M_TC | M_IP | (32'd3 << 18));
    wr(A_CNT, 8); wr(A_ADR, 32'hC000);
    wait_clear(M_CUR | M_CYC);
    rd(A_CSR, v); chk("R7 tc without ip", v & (M_TC | M_IP), M_TC);
    chk("R7 no irq", {31'b0, irq}, 0);

    // R7 device interrupt, R9 write-back clears, R10
    wr(A_CSR, M_IEN | M_TC);
    @(negedge clk); dev_irq = 1; @(negedge clk); dev_irq = 0;
    rd(A_CSR, v); chk("R7 device ip without tc", v & (M_TC | M_IP), M_IP);
    chk("R10 irq on device event", {31'b0, irq}, 1);
    wr(A_CSR, v);
    rd(A_CSR, v); chk("R9 write-back clears ip", v & (M_IP | M_IEN), M_IEN);
    chk("R9 irq low", {31'b0, irq}, 0);

    // R8 memory error
    err_inj = 1; bursts = 0;
    wr(A_CSR, M_IEN | M_EN);
    wr(A_CNT, 32); wr(A_ADR, 32'hD000);
    repeat (10) @(negedge clk);
    err_inj = 0;
    rd(A_CSR, v); chk("R8 ep set, enable cleared", v & (M_EP | M_EN | M_CUR), M_EP | M_CUR);
    rd(A_CNT, v); chk("R8 count unchanged", v, 32);
    chk("R8 one burst", 32'(bursts), 1);
    chk("R10 irq on error", {31'b0, irq}, 1);
    wr(A_CSR, M_IEN | M_EP);
    rd(A_CSR, v); chk("R9 ep cleared", v & M_EP, 0);

    // R11 drain with outstanding request
    soft_reset();
    ack_hold = 1;
    wr(A_CSR, M_EN);
    wr(A_CNT, 16); wr(A_ADR, 32'hE000);
    repeat (3) @(negedge clk);
    chk("R12 request pending", {31'b0, mem_req}, 1);
    wr(A_CSR, M_RST);
    wr(A_CSR, M_IEN);
    repeat (4) @(negedge clk);
    rd(A_CSR, v); chk("R11 draining bits", v & (M_DRN | M_CYC | M_IEN), M_DRN | M_CYC);
    ack_hold = 0;
    repeat (6) @(negedge clk);
    rd(A_CSR, v); chk("R11 cleared after drain", v, 0);
    rd(A_ADR, v); chk("R11 address cleared", v, 0);
    chk("R11 no request", {31'b0, mem_req}, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule